// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block produces data addresses for signal-processing loops. It keeps a number of pointer sets (four by default). Each set has four words: an index, a base, a length and a modifier, all 32 bits wide by default. Each operation strobe updates one chosen index by one chosen modifier. The two choices are independent of each other. The update is either an add or a subtract.

When the selected set's length is zero, the step is plain wrap-around arithmetic. When the length is nonzero, the index moves circularly inside the window that starts at the base and spans the length. A step that runs past the window gets a single correction by the length. A separate bit-reversed add mode serves FFT reordering. In that mode the carries of the addition run from the top bit toward bit zero, and the base and length play no part.

The new index is presented, registered, on an update port one cycle after the strobe. The index array can also be inspected through a registered read port. Software or a sequencer loads the four words of each set through one shared write port.

Top module: `agen_circ`

## Requirements
- R1: While reset is high and in the cycle after it, `upd_valid` is 0 and `upd_data` is 0. Every word of every set clears to 0, so `rd_data` reads 0 for any set after reset.
- R2: A write with `wr_en` high stores `wr_data` into the word of set `wr_set` that `wr_kind` picks (0 = index, 1 = base, 2 = length, 3 = modifier). `rd_data` returns the index of set `rd_sel` as it stood at the previous clock edge.
- R3: `op_idx` picks the index and base/length set. `op_mod` picks the modifier set. Any pairing is allowed, for example index 0 with modifier 3.
- R4: With a length of 0 and `op_rev` low, an add gives I+M and a subtract gives I−M, both modulo 2^32.
- R5: With a nonzero length, an add computes I+M. If that value is at least B+L, L is subtracted exactly once. Otherwise I+M is kept, even when it lies below the base.
- R6: With a nonzero length, a subtract computes I−M. If that value is below B, or the subtraction borrows, L is added exactly once. Otherwise I−M is kept.
- R7: The bounds compare unsigned, with B+L and I+M formed 33 bits wide. A window that ends above 2^32 therefore causes no false wrap.
- R8: With `op_rev` high, the modifier is added with carries running from bit 31 toward bit 0, and `op_sub` is ignored. Base and length have no effect.
- R9: If an index write and an operation name the same index in one cycle, the write wins. The index takes `wr_data`, and the operation is dropped with no `upd_valid`.
- R10: An accepted operation raises `upd_valid` with the new index on `upd_data` one cycle after the strobe. The new index is readable on `rd_data` one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Word select: 0 index, 1 base, 2 length, 3 modifier |
| wr_set | input | 2 | Set written |
| wr_data | input | 32 | Write value |
| op_valid | input | 1 | Operation strobe |
| op_idx | input | 2 | Index (and base/length) set updated |
| op_mod | input | 2 | Modifier set applied |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_rev | input | 1 | 1 = bit-reversed add |
| rd_sel | input | 2 | Index set to read |
| rd_data | output | 32 | Registered index read |
| upd_valid | output | 1 | New index valid |
| upd_data | output | 32 | New index value |

## Verification
A wrong internal word shows up on `upd_data` one cycle after the first operation that uses it. That covers a corrupted base or length, which moves or drops a wrap, and a mis-selected modifier. A stale or misrouted index is also visible on `rd_data` one cycle later. Any of these appears at the ports within two cycles of the stimulus that exposes it. The bench keeps its own shadow copy of every word and predicts each update from the requirements. It therefore catches a single bad wrap decision, a carry running the wrong way, or a lost write priority on the first operation affected.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_BASE = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_MOD  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic sub;
    logic rev;
  } step_mode_t;
endpackage

// File: rtl/agen_regfile.sv
module agen_regfile #(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  localparam int SW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_set,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_set,
  input  logic [AW-1:0] upd_val,
  input  logic [SW-1:0] op_idx,
  input  logic [SW-1:0] op_mod,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] cur_i,
  output logic [AW-1:0] cur_b,
  output logic [AW-1:0] cur_l,
  output logic [AW-1:0] cur_m,
  output logic [AW-1:0] rd_q
);
  import agen_pkg::*;

  logic [NSETS-1:0][AW-1:0] i_arr, b_arr, l_arr, m_arr;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic [AW-1:0] i_r, b_r, l_r, m_r;
    logic          hit;
    assign hit = wr_en && (wr_set == SW'(g));

    // Index: write port has priority over the step result.
    always_ff @(posedge clk) begin
      if (rst) begin
        i_r <= '0;
      end else if (hit && wr_kind == KIND_IDX) begin
        i_r <= wr_data;
      end else if (upd_en && upd_set == SW'(g)) begin
        i_r <= upd_val;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        b_r <= '0;
        l_r <= '0;
        m_r <= '0;
      end else if (hit) begin
        case (wr_kind)
          KIND_BASE: b_r <= wr_data;
          KIND_LEN:  l_r <= wr_data;
          KIND_MOD:  m_r <= wr_data;
          default:   ;
        endcase
      end
    end

    assign i_arr[g] = i_r;
    assign b_arr[g] = b_r;
    assign l_arr[g] = l_r;
    assign m_arr[g] = m_r;
  end

  assign cur_i = i_arr[op_idx];
  assign cur_b = b_arr[op_idx];
  assign cur_l = l_arr[op_idx];
  assign cur_m = m_arr[op_mod];

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= i_arr[rd_sel];
  end
endmodule

// File: rtl/agen_bitrev_add.sv
module agen_bitrev_add #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] y
);
  logic [AW-1:0] a_rev, b_rev, s_rev;

  for (genvar k = 0; k < AW; k++) begin : g_swap
    assign a_rev[k] = a[AW-1-k];
    assign b_rev[k] = b[AW-1-k];
    assign y[k]     = s_rev[AW-1-k];
  end

  // Normal carry chain on mirrored operands = carries running MSB to LSB.
  assign s_rev = a_rev + b_rev;
endmodule

// File: rtl/agen_step.sv
module agen_step #(
  parameter int AW       = 32,
  parameter bit HAS_BREV = 1'b1
) (
  input  logic              idx,
  input  logic [AW-1:0]     cur_i,
  input  logic [AW-1:0]     cur_b,
  input  logic [AW-1:0]     cur_l,
  input  logic [AW-1:0]     cur_m,
  input  agen_pkg::step_mode_t mode,
  output logic [AW-1:0]     nxt
);
  logic [AW:0]   sum_w, dif_w, top_w;
  logic [AW-1:0] lin_nxt, rev_nxt;
  logic          circ, over, under;

  assign circ  = |cur_l;
  assign sum_w = {1'b0, cur_i} + {1'b0, cur_m};
  assign dif_w = {1'b0, cur_i} - {1'b0, cur_m};
  assign top_w = {1'b0, cur_b} + {1'b0, cur_l};
  assign over  = circ && (sum_w >= top_w);
  assign under = circ && (dif_w[AW] || (dif_w[AW-1:0] < cur_b));

  always_comb begin
    if (mode.sub) lin_nxt = under ? dif_w[AW-1:0] + cur_l : dif_w[AW-1:0];
    else          lin_nxt = over  ? sum_w[AW-1:0] - cur_l : sum_w[AW-1:0];
  end

  if (HAS_BREV) begin : g_brev
    agen_bitrev_add #(.AW(AW)) u_brev (.a(cur_i), .b(cur_m), .y(rev_nxt));
  end else begin : g_nobrev
    assign rev_nxt = sum_w[AW-1:0];
  end

  assign nxt = (mode.rev && !idx) ? rev_nxt : lin_nxt;
endmodule

// File: rtl/agen_circ.sv
module agen_circ #(
  parameter int AW       = 32,
  parameter int NSETS    = 4,
  parameter bit HAS_BREV = 1'b1,
  localparam int SW      = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_set,
  input  logic [AW-1:0] wr_data,
  input  logic          op_valid,
  input  logic [SW-1:0] op_idx,
  input  logic [SW-1:0] op_mod,
  input  logic          op_sub,
  input  logic          op_rev,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_data,
  output logic          upd_valid,
  output logic [AW-1:0] upd_data
);
  import agen_pkg::*;

  logic [AW-1:0] sel_i, sel_b, sel_l, sel_m, step_val;
  logic          op_blocked, op_take;
  step_mode_t    mode;

  assign op_blocked = wr_en && (wr_kind == KIND_IDX) && (wr_set == op_idx);
  assign op_take    = op_valid && !op_blocked;
  assign mode.sub   = op_sub && !op_rev;
  assign mode.rev   = op_rev;

  agen_regfile #(.AW(AW), .NSETS(NSETS)) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_set(wr_set), .wr_data(wr_data),
    .upd_en(op_take), .upd_set(op_idx), .upd_val(step_val),
    .op_idx(op_idx), .op_mod(op_mod), .rd_sel(rd_sel),
    .cur_i(sel_i), .cur_b(sel_b), .cur_l(sel_l), .cur_m(sel_m),
    .rd_q(rd_data)
  );

  agen_step #(.AW(AW), .HAS_BREV(HAS_BREV)) u_step (
    .idx(1'b0), .cur_i(sel_i), .cur_b(sel_b), .cur_l(sel_l), .cur_m(sel_m),
    .mode(mode), .nxt(step_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      upd_data  <= '0;
    end else begin
      upd_valid <= op_take;
      if (op_take) upd_data <= step_val;
    end
  end
endmodule

// File: rtl/agen_circ_chk.sv
module agen_circ_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          op_sub,
  input logic          op_rev,
  input logic          op_blocked,
  input logic [AW-1:0] sel_i,
  input logic [AW-1:0] sel_b,
  input logic [AW-1:0] sel_l,
  input logic [AW-1:0] sel_m,
  input logic          upd_valid,
  input logic [AW-1:0] upd_data
);
  logic [AW:0] top_w;
  logic        in_win, circ_go;
  assign top_w   = {1'b0, sel_b} + {1'b0, sel_l};
  assign in_win  = (sel_i >= sel_b) && ({1'b0, sel_i} < top_w);
  assign circ_go = op_valid && !op_blocked && !op_rev && (sel_l != '0)
                   && in_win && (sel_m <= sel_l);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!upd_valid && upd_data == '0));

  // R10
  upd_follows_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_blocked) |=> upd_valid);

  // R9
  blocked_op_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_blocked) |=> !upd_valid);

  // R4
  linear_add_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_blocked && !op_rev && !op_sub && sel_l == '0)
    |=> (upd_data == $past(sel_i) + $past(sel_m)));

  // R5
  circ_stays_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    circ_go |=> (upd_data >= $past(sel_b)
                 && {1'b0, upd_data} < $past(top_w)));

  // R8
  brev_zero_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_blocked && op_rev && sel_m == '0)
    |=> (upd_data == $past(sel_i)));
endmodule

bind agen_circ agen_circ_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub),
  .op_rev(op_rev), .op_blocked(op_blocked),
  .sel_i(sel_i), .sel_b(sel_b), .sel_l(sel_l), .sel_m(sel_m),
  .upd_valid(upd_valid), .upd_data(upd_data)
);

// File: tb/tb_agen_circ.sv
module tb_agen_circ;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0, wr_set = '0;
  logic [31:0] wr_data = '0;
  logic        op_valid = 1'b0, op_sub = 1'b0, op_rev = 1'b0;
  logic [1:0]  op_idx = '0, op_mod = '0, rd_sel = '0;
  logic [31:0] rd_data, upd_data;
  logic        upd_valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mi[4], mb[4], ml[4], mm[4];

  always #2 clk = ~clk;

  agen_circ dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_set(wr_set),
    .wr_data(wr_data), .op_valid(op_valid), .op_idx(op_idx), .op_mod(op_mod),
    .op_sub(op_sub), .op_rev(op_rev), .rd_sel(rd_sel), .rd_data(rd_data),
    .upd_valid(upd_valid), .upd_data(upd_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rev_add(logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    logic        c;
    logic [1:0]  s;
    c = 1'b0;
    for (int k = 31; k >= 0; k--) begin
      s = 2'(a[k]) + 2'(b[k]) + 2'(c);
      r[k] = s[0];
      c = s[1];
    end
    return r;
  endfunction

  function automatic logic [31:0] model(int s, int mo, bit sub, bit rev);
    longint t, bi, li;
    if (rev) return rev_add(mi[s], mm[mo]);
    bi = longint'({32'b0, mb[s]});
    li = longint'({32'b0, ml[s]});
    if (sub) begin
      t = longint'({32'b0, mi[s]}) - longint'({32'b0, mm[mo]});
      if (li != 0 && t < bi) t = t + li;
    end else begin
      t = longint'({32'b0, mi[s]}) + longint'({32'b0, mm[mo]});
      if (li != 0 && t >= bi + li) t = t - li;
    end
    return t[31:0];
  endfunction

  task automatic wr(int kind, int s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_set = 2'(s); wr_data = d;
    case (kind)
      0: mi[s] = d;
      1: mb[s] = d;
      2: ml[s] = d;
      default: mm[s] = d;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(int s, logic [31:0] i, logic [31:0] b, logic [31:0] l, logic [31:0] m);
    wr(0, s, i); wr(1, s, b); wr(2, s, l); wr(3, s, m);
  endtask

  // Driver: pushes the expected update into the scoreboard.
  task automatic do_op(int s, int mo, bit sub, bit rev, string req);
    @(negedge clk);
    exp_q.push_back(model(s, mo, sub, rev));
    tag_q.push_back(req);
    mi[s] = model(s, mo, sub, rev);
    op_valid = 1'b1; op_idx = 2'(s); op_mod = 2'(mo); op_sub = sub; op_rev = rev;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic rd_check(int s, string req);
    @(negedge clk);
    rd_sel = 2'(s);
    @(negedge clk);
    check(req, rd_data, mi[s]);
  endtask

  // Monitor: pops and compares as updates appear.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && upd_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: actual unexpected update %h expected none", upd_data);
        end else begin
          check(tag_q.pop_front(), upd_data, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 4; s++) begin mi[s] = 0; mb[s] = 0; ml[s] = 0; mm[s] = 0; end
    repeat (3) @(negedge clk);
    check("R1 upd_valid", 32'(upd_valid), 32'h0);
    check("R1 upd_data", upd_data, 32'h0);
    rst = 1'b0;
    rd_check(2, "R1 rd_data");

    load(0, 32'h1000, 32'h110E, 32'hA1, 32'h5);
    load(1, 32'h1100, 32'h110C, 32'hB2, 32'h4);
    load(2, 32'h1010, 32'h110A, 32'hC3, 32'h3);
    load(3, 32'h1001, 32'h1108, 32'hD4, 32'h2);
    rd_check(1, "R2");

    // R5 below-base adds, matched and crossed pairings (R3)
    for (int s = 0; s < 4; s++) do_op(s, s, 0, 0, "R5");
    for (int s = 0; s < 4; s++) do_op(s, (s + 1) % 4, 0, 0, "R3");
    // R6 subtract below base wraps up by L
    for (int s = 0; s < 4; s++) do_op(s, (s + 2) % 4, 1, 0, "R6");
    for (int s = 0; s < 4; s++) do_op(s, (s + 3) % 4, 1, 0, "R6");
    // R8 bit-reversed, base and length ignored, op_sub ignored
    for (int s = 0; s < 4; s++) do_op(s, (s + 3) % 4, 0, 1, "R8");
    for (int s = 0; s < 4; s++) do_op(s, (s + 2) % 4, s[0], 1, "R8");
    rd_check(0, "R10");

    // R5 crossing the top wraps down once
    wr(0, 0, 32'h11AD);
    do_op(0, 0, 0, 0, "R5");
    // R4 linear with zero length
    load(2, 32'hFFFF_FFFE, 32'h0000_2000, 32'h0, 32'h5);
    do_op(2, 2, 0, 0, "R4");
    do_op(2, 2, 1, 0, "R4");
    do_op(2, 2, 1, 0, "R4");
    // R7 window above 2^32
    load(3, 32'hFFFF_FFF0, 32'hFFFF_FF00, 32'h200, 32'h4);
    do_op(3, 3, 0, 0, "R7");
    wr(3, 3, 32'h10C);
    do_op(3, 3, 0, 0, "R7");
    rd_check(3, "R10");

    // R9 collision: write wins, op dropped
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd0; wr_set = 2'd1; wr_data = 32'hABCD_0001;
    op_valid = 1'b1; op_idx = 2'd1; op_mod = 2'd1; op_sub = 1'b0; op_rev = 1'b0;
    mi[1] = 32'hABCD_0001;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0;
    check("R9 no update", 32'(upd_valid), 32'h0);
    rd_check(1, "R9");

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule